// File: doc/BRIEF.md
# Single-Error-Correcting FSM State Register

This block stands in for the present-state register of a finite state machine. Next to the state flops it keeps a set of check flops. Together they form a single-error-correcting Hamming codeword. Every cycle, the stored word is decoded and any single flipped flop is corrected in the combinational output. The upset flag is raised for that cycle. The corrected value is what the user's next-state and output logic see.

The enable is not used as a flop clock enable. It selects, in front of the flops, between the new next state and the corrected present state. As a result, the flops are rewritten with a clean codeword on every clock, even while the machine is held, and a repaired upset never lingers. The check bits are always derived from the value about to be stored. The synchronous reset loads the state flops with the reset value and the check flops with that value's code, so leaving reset is never reported as an upset. Two test-only masks flip chosen state or check flops as they are written, to model upsets.

Top module: `hfsm_state_guard`

## Requirements
- R1: The number of check flops K is the smallest value with 2^K >= N + K + 1 for N state flops; for the default N = 4 this is K = 3, and the check injection mask is K bits wide.
- R2: While `rst` is high at a clock edge, the flops load the reset value and its code. In the cycle after reset is released, `state_o` equals `RESET_VAL` and `upset_o` is 0.
- R3: With no upset, when `en_i` = 1 at a clock edge, `state_o` takes the value of `next_i`. When `en_i` = 0, `state_o` keeps its value.
- R4: If exactly one state flop is flipped, `state_o` still shows the intended value and `upset_o` is 1 in the cycle after the flip.
- R5: If exactly one check flop is flipped, `state_o` is unaffected and `upset_o` is 1 in the cycle after the flip.
- R6: A single upset is repaired at the next clock edge even with `en_i` = 0, so `upset_o` is high for one cycle only.
- R7: If an upset and `en_i` = 1 arrive in the same cycle, the register still loads `next_i` exactly.
- R8: A reset edge discards any injected flip: after reset, the state is `RESET_VAL` with `upset_o` = 0.
- R9: Code positions run from 1 to N + K. The check bits sit at the power-of-two positions, and the state bits fill the other positions in ascending order: for N = 4, state bits 0..3 sit at positions 3, 5, 6 and 7. The syndrome is the position of the flipped bit. Flipping state bits 0 and 1 together gives syndrome 6, which miscorrects state bit 2; the output is then the intended value XOR 4'b0111, with `upset_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Load `next_i` when 1, rewrite the corrected state when 0 |
| next_i | input | STATE_W | Next state from the user's next-state logic |
| inj_state_i | input | STATE_W | Test-only mask of state flops to flip as they are written |
| inj_check_i | input | CHK_W | Test-only mask of check flops to flip as they are written |
| state_o | output | STATE_W | Corrected present state |
| upset_o | output | 1 | Non-zero syndrome in the stored word this cycle |

## Verification
The embedded properties check the following on every cycle:
- leaving reset produces a clean reset state;
- a load with enable high delivers the next state even if a single flop is hit;
- a hold keeps the corrected value through a single flip;
- any single injected flip raises the flag;
- the flag drops after one cycle once injection stops.

Only the bench's scenarios can show the following, because they depend on where a specific flop sits in the code:
- each individual state and check flop is covered;
- the corrected value is exact;
- the miscorrection pattern of a double flip reveals the bit-to-position mapping;
- reset overrides an injection.

// File: rtl/hfsm_pkg.sv
package hfsm_pkg;

    // Smallest K with 2^K >= n + K + 1.
    function automatic int check_count(input int n);
        int k;
        k = 1;
        while ((1 << k) < (n + k + 1)) k++;
        return k;
    endfunction

    // Code position (1-based) of data bit i: the i-th non-power-of-two position.
    function automatic int data_pos(input int i);
        int cnt;
        cnt = 0;
        for (int p = 3; p < 65536; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == i) return p;
                cnt++;
            end
        end
        return 0;
    endfunction

    typedef enum logic {
        SRC_HOLD = 1'b0,
        SRC_LOAD = 1'b1
    } src_sel_e;

endpackage

// File: rtl/hfsm_check_gen.sv
module hfsm_check_gen
    import hfsm_pkg::*;
#(
    parameter int DATA_W = 4,
    localparam int CHK_W = check_count(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  check_o
);

    for (genvar j = 0; j < CHK_W; j++) begin : g_chk
        always_comb begin
            logic acc;
            acc = 1'b0;
            for (int i = 0; i < DATA_W; i++) begin
                if (((data_pos(i) >> j) & 1) == 1) acc = acc ^ data_i[i];
            end
            check_o[j] = acc;
        end
    end

endmodule

// File: rtl/hfsm_corrector.sv
module hfsm_corrector
    import hfsm_pkg::*;
#(
    parameter int DATA_W = 4,
    localparam int CHK_W = check_count(DATA_W)
) (
    input  logic [DATA_W-1:0] raw_state_i,
    input  logic [CHK_W-1:0]  raw_check_i,
    output logic [DATA_W-1:0] fixed_state_o,
    output logic              upset_o
);

    logic [CHK_W-1:0] recomputed;
    logic [CHK_W-1:0] syndrome;

    hfsm_check_gen #(.DATA_W(DATA_W)) u_regen (
        .data_i (raw_state_i),
        .check_o(recomputed)
    );

    assign syndrome = recomputed ^ raw_check_i;
    assign upset_o  = |syndrome;

    for (genvar i = 0; i < DATA_W; i++) begin : g_fix
        localparam logic [CHK_W-1:0] POS = CHK_W'(data_pos(i));
        assign fixed_state_o[i] = raw_state_i[i] ^ (syndrome == POS);
    end

endmodule

// File: rtl/hfsm_reg_bank.sv
module hfsm_reg_bank
    import hfsm_pkg::*;
#(
    parameter int DATA_W = 4,
    localparam int CHK_W = check_count(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] rst_state_i,
    input  logic [CHK_W-1:0]  rst_check_i,
    input  logic [DATA_W-1:0] d_state_i,
    input  logic [CHK_W-1:0]  d_check_i,
    input  logic [DATA_W-1:0] flip_state_i,
    input  logic [CHK_W-1:0]  flip_check_i,
    output logic [DATA_W-1:0] q_state_o,
    output logic [CHK_W-1:0]  q_check_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_state_o <= rst_state_i;
            q_check_o <= rst_check_i;
        end else begin
            q_state_o <= d_state_i ^ flip_state_i;
            q_check_o <= d_check_i ^ flip_check_i;
        end
    end

endmodule

// File: rtl/hfsm_state_guard.sv
module hfsm_state_guard
    import hfsm_pkg::*;
#(
    parameter int STATE_W = 4,
    parameter logic [STATE_W-1:0] RESET_VAL = STATE_W'(1),
    localparam int CHK_W = check_count(STATE_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_i,
    input  logic [STATE_W-1:0] next_i,
    input  logic [STATE_W-1:0] inj_state_i,
    input  logic [CHK_W-1:0]   inj_check_i,
    output logic [STATE_W-1:0] state_o,
    output logic               upset_o
);

    src_sel_e           sel;
    logic [STATE_W-1:0] d_state;
    logic [CHK_W-1:0]   d_check;
    logic [CHK_W-1:0]   rst_check;
    logic [STATE_W-1:0] q_state;
    logic [CHK_W-1:0]   q_check;

    // Enable folded into the data path: hold means rewrite the corrected value.
    assign sel     = en_i ? SRC_LOAD : SRC_HOLD;
    assign d_state = (sel == SRC_LOAD) ? next_i : state_o;

    hfsm_check_gen #(.DATA_W(STATE_W)) u_gen_next (
        .data_i (d_state),
        .check_o(d_check)
    );

    hfsm_check_gen #(.DATA_W(STATE_W)) u_gen_rst (
        .data_i (RESET_VAL),
        .check_o(rst_check)
    );

    hfsm_reg_bank #(.DATA_W(STATE_W)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .rst_state_i (RESET_VAL),
        .rst_check_i (rst_check),
        .d_state_i   (d_state),
        .d_check_i   (d_check),
        .flip_state_i(inj_state_i),
        .flip_check_i(inj_check_i),
        .q_state_o   (q_state),
        .q_check_o   (q_check)
    );

    hfsm_corrector #(.DATA_W(STATE_W)) u_fix (
        .raw_state_i  (q_state),
        .raw_check_i  (q_check),
        .fixed_state_o(state_o),
        .upset_o      (upset_o)
    );

    // R2: leaving reset yields the clean reset state
    a_r2_reset_clean: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (state_o == RESET_VAL && !upset_o));

    // R3 / R7: a load delivers next_i even through a single flip
    a_r3_load: assert property (@(posedge clk) disable iff (rst)
        (en_i && $countones({inj_state_i, inj_check_i}) <= 1)
        |=> state_o == $past(next_i));

    // R3 / R6: a hold keeps the corrected value through a single flip
    a_r6_hold_repair: assert property (@(posedge clk) disable iff (rst)
        (!en_i && $countones({inj_state_i, inj_check_i}) <= 1)
        |=> state_o == $past(state_o));

    // R4 / R5: any single flip is flagged
    a_r4_single_flagged: assert property (@(posedge clk) disable iff (rst)
        ($countones({inj_state_i, inj_check_i}) == 1) |=> upset_o);

    // R6: the flag lasts one cycle when no new flip arrives
    a_r6_flag_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (upset_o && !(|{inj_state_i, inj_check_i})) |=> !upset_o);

endmodule

// File: tb/hfsm_state_guard_tb.sv
module hfsm_state_guard_tb;

    localparam int N = 4;
    localparam int K_EXP = 3;
    localparam logic [N-1:0] RV = 4'b0001;

    typedef struct {
        logic [N-1:0] st;
        logic         up;
        string        tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic [N-1:0]     nxt = '0;
    logic [N-1:0]     inj_s = '0;
    logic [K_EXP-1:0] inj_c = '0;
    logic [N-1:0]     st_o;
    logic             up_o;

    int checks = 0;
    int fails  = 0;
    exp_t sb[$];
    logic [N-1:0] ms = RV;

    always #4 clk = ~clk;

    hfsm_state_guard #(.STATE_W(N), .RESET_VAL(RV)) u_dut (
        .clk(clk), .rst(rst), .en_i(en), .next_i(nxt),
        .inj_state_i(inj_s), .inj_check_i(inj_c),
        .state_o(st_o), .upset_o(up_o)
    );

    // Driver: one clock of stimulus, expected result pushed to the scoreboard.
    task automatic step(input logic r, input logic e,
                        input logic [N-1:0] fs, input logic [K_EXP-1:0] fc,
                        input logic [N-1:0] miss, input string tag);
        exp_t x;
        logic [N-1:0] n;
        @(negedge clk);
        n = ms + 4'd3;   // example FSM: advance by three
        rst = r; en = e; nxt = n; inj_s = fs; inj_c = fc;
        if (r) begin
            ms = RV;
            x.up = 1'b0;
        end else begin
            ms = (e ? n : ms) ^ miss;
            x.up = (fs != '0) || (fc != '0);
        end
        x.st = ms;
        x.tag = tag;
        sb.push_back(x);
    endtask

    // Monitor: compare after each edge.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t x;
            x = sb.pop_front();
            checks++;
            if (st_o !== x.st) begin
                fails++;
                $display("FAIL %s state: actual %b expected %b", x.tag, st_o, x.st);
            end
            checks++;
            if (up_o !== x.up) begin
                fails++;
                $display("FAIL %s upset: actual %b expected %b", x.tag, up_o, x.up);
            end
        end
    end

    initial begin
        #(8 * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        checks++;
        if ($bits(inj_c) != K_EXP || $bits(u_dut.inj_check_i) != K_EXP) begin
            fails++;
            $display("FAIL R1 check width: actual %0d expected %0d",
                     $bits(u_dut.inj_check_i), K_EXP);
        end
        step(1, 0, '0, '0, '0, "R2 reset");
        step(1, 0, '0, '0, '0, "R2 reset");
        step(0, 0, '0, '0, '0, "R2 after release");
        for (int i = 0; i < 5; i++) step(0, 1, '0, '0, '0, "R3 load");
        for (int i = 0; i < 3; i++) step(0, 0, '0, '0, '0, "R3 hold");
        for (int b = 0; b < N; b++) begin
            step(0, 0, N'(1 << b), '0, '0, "R4 state flip held");
            step(0, 0, '0, '0, '0, "R6 repaired");
        end
        for (int b = 0; b < K_EXP; b++) begin
            step(0, 0, '0, K_EXP'(1 << b), '0, "R5 check flip held");
            step(0, 1, '0, '0, '0, "R6 repaired then load");
        end
        for (int b = 0; b < N; b++) begin
            step(0, 1, N'(1 << b), '0, '0, "R7 flip with load");
            step(0, 1, '0, '0, '0, "R6 after load flip");
        end
        step(0, 1, '0, 3'b100, '0, "R7 check flip with load");
        step(0, 0, '0, '0, '0, "R6 clean");
        step(0, 0, 4'b0011, '0, 4'b0111, "R9 double flip miscorrects bit 2");
        step(0, 0, '0, '0, '0, "R9 miscorrected value rewritten");
        step(1, 1, 4'b0100, 3'b001, '0, "R8 reset overrides flip");
        step(0, 0, '0, '0, '0, "R8 clean after reset");
        step(0, 1, '0, '0, '0, "R3 load after reset");
        @(negedge clk);
        inj_s = '0; inj_c = '0; en = 1'b0;
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule